// File: doc/BRIEF.md
# Flash Sector Map and Boot Lockout Guard

This block sits beside the command decoder of a byte-wide flash array. It works out which of eleven sectors a byte address falls in and rules on each program, sector-erase or chip-erase request. The sectors have uneven sizes. A 16 KiB boot sector sits at the bottom, then two 8 KiB parameter sectors and one 32 KiB main sector, then seven 64 KiB main sectors. A granted request comes back one cycle later with the sector index and the set of sectors the erase engine must clear.

A one-way protection latch guards the boot sector. A single-cycle seal strobe from the command decoder sets it. From then on, programming or erasing the boot sector is refused with a one-cycle reject pulse, and a chip erase quietly leaves the boot sector out of its mask. Only the power-on reset clears the latch. The ordinary mode reset returns the request state machine to idle and leaves the latch alone.

When the identification mode is active, a combinational read port returns the maker code, the part code, an extra code and the latch state.

The request state machine has three states. `RQ_IDLE` has no outcome pending. `RQ_GRANT` drives a one-cycle permit. `RQ_REFUSE` drives a one-cycle reject. From any state, a valid request of a known kind moves the machine to `RQ_REFUSE` when it hits a sealed boot sector, and to `RQ_GRANT` otherwise. With no request, the machine returns to `RQ_IDLE`.

The latch state machine has two states, `LK_OPEN` and `LK_SEALED`. Its only transition is `LK_OPEN` to `LK_SEALED`, taken on the seal strobe. The power-on reset forces `LK_OPEN`.

Top module: `flash_sector_guard`

## Requirements
- R1: The sector index follows the address as listed below. A request's index appears on `sector` one cycle after the request and is held until the next request.
  - Index 0 covers 0x00000 to 0x03FFF.
  - Index 1 covers 0x04000 to 0x05FFF.
  - Index 2 covers 0x06000 to 0x07FFF.
  - Index 3 covers 0x08000 to 0x0FFFF.
  - Index 3+k covers each 64 KiB range starting at k·0x10000, for k = 1 to 7.
- R2: A request of kind 0 (program) or kind 1 (sector erase) that is not refused raises `grant` for exactly the one cycle after the request.
- R3: A granted sector erase drives `erase_mask` with only bit n set, where n is the sector index. A granted program drives `erase_mask` to zero.
- R4: A chip erase (kind 2) is always granted. Its mask is 0x7FF when unsealed and 0x7FE (bit 0, the boot sector, cleared) when sealed.
- R5: While sealed, a program or sector erase that targets index 0 raises `reject` for exactly one cycle, with `grant` low and `erase_mask` zero. Such requests to other sectors are still granted.
- R6: A `seal` strobe seals the boot sector permanently. The mode reset `rst_n` does not clear the seal. Only `por_n` does. A request in the same cycle as the strobe is judged against the state before the strobe.
- R7: While `id_mode` is high, `id_data` returns 0x1F at address 0, 0x13 at address 1 and 0x0F at address 3. Every other address returns 0x00. While `id_mode` is low, `id_data` is 0x00.
- R8: While `id_mode` is high, address 2 returns the seal state in bit 0 (1 means sealed, 0 means programmable), with bits 7:1 zero.
- R9: Request kind 3 is ignored. Neither `grant` nor `reject` is raised, `erase_mask` stays zero, and `sector` keeps its previous value.
- R10: After reset, `grant`, `reject`, `erase_mask` and `sector` are all zero, and the seal is open after `por_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low mode reset (request state machine only) |
| por_n | input | 1 | Active-low power-on reset (also clears the seal) |
| req_valid | input | 1 | Request strobe |
| req_kind | input | 2 | 0 program, 1 sector erase, 2 chip erase, 3 none |
| addr | input | 19 | Byte address for the request and for identification reads |
| seal | input | 1 | One-cycle strobe that seals the boot sector |
| id_mode | input | 1 | Identification read mode |
| sector | output | 4 | Registered sector index of the last request |
| grant | output | 1 | One-cycle permit pulse |
| reject | output | 1 | One-cycle refusal pulse |
| erase_mask | output | 11 | Sectors to clear for the granted request |
| id_data | output | 8 | Identification read data |

## Verification
The bench builds the block with its default 19-bit address, which gives all eleven sectors and the full 0x7FFFF range. The first and last byte of every uneven sector boundary are therefore reachable, as are a mid-range main sector and the top sector, and the chip-erase mask can be checked at full width. The sealed runs cover the interplay of the seal with both resets and with the identification read of the latch.

// File: rtl/fsg_pkg.sv
package fsg_pkg;

    typedef enum logic [1:0] {
        REQ_PROG       = 2'd0,
        REQ_SECT_ERASE = 2'd1,
        REQ_CHIP_ERASE = 2'd2,
        REQ_NONE       = 2'd3
    } req_kind_t;

    typedef enum logic {
        LK_OPEN   = 1'b0,
        LK_SEALED = 1'b1
    } lock_state_t;

    typedef enum logic [1:0] {
        RQ_IDLE   = 2'd0,
        RQ_GRANT  = 2'd1,
        RQ_REFUSE = 2'd2
    } rq_state_t;

    localparam logic [7:0] ID_MAKER = 8'h1F;
    localparam logic [7:0] ID_PART  = 8'h13;
    localparam logic [7:0] ID_EXTRA = 8'h0F;

endpackage

// File: rtl/fsg_sector_map.sv
module fsg_sector_map #(
    parameter int ADDR_W   = 19,
    parameter int NUM_SECT = 3 + (1 << (ADDR_W - 16)),
    parameter int IDX_W    = $clog2(NUM_SECT)
) (
    input  logic [ADDR_W-1:13]  addr_hi,
    output logic [IDX_W-1:0]    sector,
    output logic [NUM_SECT-1:0] onehot
);
    localparam int UP_W = ADDR_W - 16;

    logic [UP_W-1:0] upper;

    always_comb begin
        upper = addr_hi[ADDR_W-1:16];
        if (upper != '0) begin
            sector = IDX_W'(3) + IDX_W'(upper);
        end else if (addr_hi[15]) begin
            sector = IDX_W'(3);
        end else if (addr_hi[14]) begin
            sector = addr_hi[13] ? IDX_W'(2) : IDX_W'(1);
        end else begin
            sector = '0;
        end
    end

    for (genvar g = 0; g < NUM_SECT; g++) begin : g_dec
        assign onehot[g] = (sector == IDX_W'(g));
    end

endmodule

// File: rtl/fsg_lock_fsm.sv
module fsg_lock_fsm
    import fsg_pkg::*;
(
    input  logic clk,
    input  logic por_n,
    input  logic seal_cmd,
    output logic sealed
);
    lock_state_t state, state_nxt;

    always_comb begin
        state_nxt = state;
        unique case (state)
            LK_OPEN:   if (seal_cmd) state_nxt = LK_SEALED;
            LK_SEALED: state_nxt = LK_SEALED;
        endcase
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) state <= LK_OPEN;
        else        state <= state_nxt;
    end

    always_comb begin
        sealed = (state == LK_SEALED);
    end

    AST_SEAL_STICKY: assert property (@(posedge clk) disable iff (!por_n)
        sealed |=> sealed);  // R6

    AST_SEAL_SETS: assert property (@(posedge clk) disable iff (!por_n)
        seal_cmd |=> sealed);  // R6

endmodule

// File: rtl/fsg_id_rom.sv
module fsg_id_rom
    import fsg_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input  logic              id_mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic              sealed,
    output logic [7:0]        id_data
);
    always_comb begin
        id_data = 8'h00;
        if (id_mode) begin
            unique case (addr)
                ADDR_W'(0): id_data = ID_MAKER;
                ADDR_W'(1): id_data = ID_PART;
                ADDR_W'(2): id_data = {7'b0, sealed};
                ADDR_W'(3): id_data = ID_EXTRA;
                default:    id_data = 8'h00;
            endcase
        end
    end

endmodule

// File: rtl/flash_sector_guard.sv
module flash_sector_guard
    import fsg_pkg::*;
#(
    parameter int ADDR_W = 19,
    localparam int NUM_SECT = 3 + (1 << (ADDR_W - 16)),
    localparam int IDX_W    = $clog2(NUM_SECT)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                por_n,
    input  logic                req_valid,
    input  logic [1:0]          req_kind,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                seal,
    input  logic                id_mode,
    output logic [IDX_W-1:0]    sector,
    output logic                grant,
    output logic                reject,
    output logic [NUM_SECT-1:0] erase_mask,
    output logic [7:0]          id_data
);
    localparam logic [NUM_SECT-1:0] ALL_SECT  = '1;
    localparam logic [NUM_SECT-1:0] BOOT_BIT  = NUM_SECT'(1);

    logic                fsm_rst_n;
    logic                sealed;
    logic [IDX_W-1:0]    sect_now;
    logic [NUM_SECT-1:0] sect_onehot;
    req_kind_t           kind;
    logic                hit;
    logic                boot_blocked;
    logic [NUM_SECT-1:0] mask_d;

    rq_state_t           state, state_nxt;
    logic [IDX_W-1:0]    sector_q;
    logic [NUM_SECT-1:0] mask_q;

    assign fsm_rst_n = rst_n & por_n;

    fsg_sector_map #(.ADDR_W(ADDR_W), .NUM_SECT(NUM_SECT), .IDX_W(IDX_W)) u_map (
        .addr_hi (addr[ADDR_W-1:13]),
        .sector  (sect_now),
        .onehot  (sect_onehot)
    );

    fsg_lock_fsm u_lock (
        .clk      (clk),
        .por_n    (por_n),
        .seal_cmd (seal),
        .sealed   (sealed)
    );

    fsg_id_rom #(.ADDR_W(ADDR_W)) u_id (
        .id_mode (id_mode),
        .addr    (addr),
        .sealed  (sealed),
        .id_data (id_data)
    );

    // Decision for the request presented this cycle
    always_comb begin
        kind         = req_kind_t'(req_kind);
        hit          = req_valid && (kind != REQ_NONE);
        boot_blocked = sealed && (sect_now == '0) && (kind != REQ_CHIP_ERASE);
        mask_d       = '0;
        unique case (kind)
            REQ_SECT_ERASE: mask_d = sect_onehot;
            REQ_CHIP_ERASE: mask_d = sealed ? (ALL_SECT & ~BOOT_BIT) : ALL_SECT;
            default:        mask_d = '0;
        endcase
        if (boot_blocked) mask_d = '0;
    end

    // Next-state logic
    always_comb begin
        state_nxt = RQ_IDLE;
        unique case (state)
            RQ_IDLE, RQ_GRANT, RQ_REFUSE: begin
                if (hit) state_nxt = boot_blocked ? RQ_REFUSE : RQ_GRANT;
                else     state_nxt = RQ_IDLE;
            end
            default: state_nxt = RQ_IDLE;
        endcase
    end

    // State and captured request
    always_ff @(posedge clk or negedge fsm_rst_n) begin
        if (!fsm_rst_n) begin
            state    <= RQ_IDLE;
            sector_q <= '0;
            mask_q   <= '0;
        end else begin
            state  <= state_nxt;
            mask_q <= (hit && !boot_blocked) ? mask_d : '0;
            if (hit) sector_q <= sect_now;
        end
    end

    // Outputs
    always_comb begin
        grant      = 1'b0;
        reject     = 1'b0;
        erase_mask = '0;
        sector     = sector_q;
        unique case (state)
            RQ_IDLE:   ;
            RQ_GRANT:  begin grant = 1'b1; erase_mask = mask_q; end
            RQ_REFUSE: reject = 1'b1;
            default:   ;
        endcase
    end

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!fsm_rst_n)
        !(grant && reject));  // R5

    AST_MAP_RANGE: assert property (@(posedge clk) disable iff (!fsm_rst_n)
        (sect_now < IDX_W'(NUM_SECT)) && $onehot(sect_onehot));  // R1

    AST_BOOT_REFUSED: assert property (@(posedge clk) disable iff (!fsm_rst_n)
        (req_valid && sealed && sect_now == '0 &&
         (kind == REQ_PROG || kind == REQ_SECT_ERASE)) |=> (reject && erase_mask == '0));  // R5

    AST_CHIP_SKIPS_BOOT: assert property (@(posedge clk) disable iff (!fsm_rst_n)
        (req_valid && kind == REQ_CHIP_ERASE && sealed) |=> (grant && !erase_mask[0]));  // R4

    AST_SECT_ONE_BIT: assert property (@(posedge clk) disable iff (!fsm_rst_n)
        (req_valid && kind == REQ_SECT_ERASE && !(sealed && sect_now == '0))
        |=> (grant && $countones(erase_mask) == 1));  // R3

    AST_NONE_IGNORED: assert property (@(posedge clk) disable iff (!fsm_rst_n)
        (req_valid && kind == REQ_NONE) |=> (!grant && !reject && $stable(sector)));  // R9

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!fsm_rst_n)
        (reject && !$past(req_valid)) |=> !reject);  // R5

endmodule

// File: tb/flash_sector_guard_test.sv
module flash_sector_guard_test;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 13;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        por_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = 2'd3;
    logic [18:0] addr = '0;
    logic        seal = 1'b0;
    logic        id_mode = 1'b0;
    logic [3:0]  sector;
    logic        grant;
    logic        reject;
    logic [10:0] erase_mask;
    logic [7:0]  id_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_sector_guard uut (
        .clk(clk), .rst_n(rst_n), .por_n(por_n), .req_valid(req_valid),
        .req_kind(req_kind), .addr(addr), .seal(seal), .id_mode(id_mode),
        .sector(sector), .grant(grant), .reject(reject),
        .erase_mask(erase_mask), .id_data(id_data)
    );

    // {addr, kind, sector, grant, mask}
    localparam logic [36:0] VEC [NV] = '{
        {19'h00000, 2'd0, 4'd0,  1'b1, 11'h000},
        {19'h03FFF, 2'd1, 4'd0,  1'b1, 11'h001},
        {19'h04000, 2'd1, 4'd1,  1'b1, 11'h002},
        {19'h05FFF, 2'd1, 4'd1,  1'b1, 11'h002},
        {19'h06000, 2'd1, 4'd2,  1'b1, 11'h004},
        {19'h07FFF, 2'd1, 4'd2,  1'b1, 11'h004},
        {19'h08000, 2'd1, 4'd3,  1'b1, 11'h008},
        {19'h0FFFF, 2'd1, 4'd3,  1'b1, 11'h008},
        {19'h10000, 2'd1, 4'd4,  1'b1, 11'h010},
        {19'h2ABCD, 2'd0, 4'd5,  1'b1, 11'h000},
        {19'h65432, 2'd1, 4'd9,  1'b1, 11'h200},
        {19'h7FFFF, 2'd1, 4'd10, 1'b1, 11'h400},
        {19'h00555, 2'd2, 4'd0,  1'b1, 11'h7FF}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [18:0] a, input logic [1:0] k);
        @(negedge clk);
        addr = a; req_kind = k; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; req_kind = 2'd3;
    endtask

    task automatic expect_out(input string tag, input logic [3:0] s, input logic g,
                              input logic r, input logic [10:0] m);
        check({tag, " sector"}, 32'(sector), 32'(s));
        check({tag, " grant"},  32'(grant),  32'(g));
        check({tag, " reject"}, 32'(reject), 32'(r));
        check({tag, " mask"},   32'(erase_mask), 32'(m));
    endtask

    task automatic id_read(input string tag, input logic [18:0] a, input logic [7:0] exp);
        @(negedge clk);
        id_mode = 1'b1; addr = a;
        #1;
        check(tag, 32'(id_data), 32'(exp));
    endtask

    initial begin
        repeat (2) @(negedge clk);
        // R10: reset state
        expect_out("R10 reset", 4'd0, 1'b0, 1'b0, 11'h000);
        rst_n = 1'b1; por_n = 1'b1;

        // R1 R2 R3 R4: table walk, unsealed
        for (int i = 0; i < NV; i++) begin
            issue(VEC[i][36:18], VEC[i][17:16]);
            expect_out($sformatf("R1/R2/R3/R4 vec%0d", i), VEC[i][15:12], VEC[i][11], 1'b0, VEC[i][10:0]);
        end
        @(negedge clk);
        check("R2 grant single cycle", 32'(grant), 32'd0);

        // R9: kind 3 ignored, sector held from last (0)
        issue(19'h7FFFF, 2'd3);
        expect_out("R9 none", 4'd0, 1'b0, 1'b0, 11'h000);

        // R7 R8: id reads unsealed
        id_read("R7 maker", 19'h0, 8'h1F);
        id_read("R7 part", 19'h1, 8'h13);
        id_read("R7 extra", 19'h3, 8'h0F);
        id_read("R7 other", 19'h4, 8'h00);
        id_read("R7 high other", 19'h40000, 8'h00);
        id_read("R8 open", 19'h2, 8'h00);
        @(negedge clk); id_mode = 1'b0; addr = 19'h0; #1;
        check("R7 id off", 32'(id_data), 32'h00);

        // R6: seal with a same-cycle boot program judged against the open state
        @(negedge clk);
        seal = 1'b1; addr = 19'h00100; req_kind = 2'd0; req_valid = 1'b1;
        @(negedge clk);
        seal = 1'b0; req_valid = 1'b0; req_kind = 2'd3;
        expect_out("R6 same-cycle", 4'd0, 1'b1, 1'b0, 11'h000);
        id_read("R8 sealed", 19'h2, 8'h01);
        @(negedge clk); id_mode = 1'b0;

        // R5: refused boot writes
        issue(19'h01234, 2'd0);
        expect_out("R5 prog boot", 4'd0, 1'b0, 1'b1, 11'h000);
        @(negedge clk);
        check("R5 reject single cycle", 32'(reject), 32'd0);
        issue(19'h03FFF, 2'd1);
        expect_out("R5 erase boot", 4'd0, 1'b0, 1'b1, 11'h000);
        issue(19'h04000, 2'd1);
        expect_out("R5 param still open", 4'd1, 1'b1, 1'b0, 11'h002);
        issue(19'h7F000, 2'd0);
        expect_out("R5 main prog open", 4'd10, 1'b1, 1'b0, 11'h000);

        // R4: sealed chip erase
        issue(19'h00555, 2'd2);
        expect_out("R4 chip sealed", 4'd0, 1'b1, 1'b0, 11'h7FE);

        // R6: mode reset keeps the seal
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        expect_out("R10 mode reset", 4'd0, 1'b0, 1'b0, 11'h000);
        rst_n = 1'b1;
        issue(19'h00555, 2'd2);
        expect_out("R6 seal survives rst_n", 4'd0, 1'b1, 1'b0, 11'h7FE);

        // R6 R10: power-on reset reopens
        @(negedge clk); por_n = 1'b0;
        @(negedge clk); por_n = 1'b1;
        id_read("R10 por open", 19'h2, 8'h00);
        @(negedge clk); id_mode = 1'b0;
        issue(19'h00010, 2'd0);
        expect_out("R6 por reopens boot", 4'd0, 1'b1, 1'b0, 11'h000);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule